// File: doc/BRIEF.md
# Video Frame Line-Count Checker

This block watches a video beat stream that carries frame-start, line-end, frame-end and pixel-present markers. Inside each frame it counts completed lines and, within the current line, received pixels. When the frame closes, it compares the number of lines it saw against a programmed expected count. It raises one flag when it saw fewer lines than expected and a different flag when it saw more. A third flag reports a frame that was abandoned because a new frame started before the old one ended.

The stream may or may not carry line-end markers. When it does not, the block ends a line itself once the programmed line width worth of pixels has arrived. The three flags feed a small interrupt set: a sticky raw bit per event, a per-bit enable, a masked status and one combined interrupt line. Software clears a raw bit by pulsing a write-one-to-clear input.

The checker is a pure observer. It never applies back-pressure: `in_ready` is always high, and a beat counts whenever `in_valid` is high. Marker inputs are ignored in cycles where `in_valid` is low. The upstream source may pause at any time by dropping `in_valid`.

Top module: `frm_line_checker`

## Requirements
- R1: After reset, `irq_raw`, `irq_stat` and `irq` are all zero, `in_ready` is 1 and no frame is open.
- R2: `in_ready` stays 1 at all times. Marker and pixel inputs have no effect in cycles where `in_valid` is low.
- R3: With `cfg_has_eol` = 1, each accepted beat with `in_eol` set inside an open frame completes one line. The pixel count does not end lines in this mode.
- R4: With `cfg_has_eol` = 0, `in_eol` is ignored. A line completes on the accepted pixel that brings the current line to `cfg_width` pixels. A `cfg_width` of 0 never completes a line.
- R5: On an accepted `in_eof` inside an open frame, with checking enabled, the frame closes. `irq_raw[0]` is set if the line total is below `cfg_lines`. `irq_raw[1]` is set if the total is above `cfg_lines`. Neither is set if the two are equal. The flag is visible from the clock edge that accepts the frame-end beat.
- R6: With `cfg_chk_en` = 0, a frame end never sets `irq_raw[0]` or `irq_raw[1]`.
- R7: An accepted `in_sof` while a frame is still open sets `irq_raw[2]` (discard). The line and pixel counts restart from zero for the new frame.
- R8: Beats accepted while no frame is open and without `in_sof` are ignored. A frame end outside a frame makes no comparison.
- R9: A 1 on `irq_clr[i]` clears `irq_raw[i]` at the next edge. If a new event sets the same bit in that same cycle, the bit stays set.
- R10: `irq_stat` equals `irq_raw & irq_ena`, and `irq` is the OR of `irq_stat`. `irq_ena` never alters `irq_raw`.
- R11: Within a single beat, markers take effect in the order frame start, pixel, line end, frame end. The line count saturates at 4095 for the default 12-bit width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat present |
| in_ready | output | 1 | Always 1; the checker never stalls the stream |
| in_sof | input | 1 | Beat opens a frame |
| in_pix | input | 1 | Beat carries one pixel |
| in_eol | input | 1 | Beat closes a line (used when cfg_has_eol = 1) |
| in_eof | input | 1 | Beat closes the frame |
| cfg_lines | input | 12 | Expected lines per frame |
| cfg_width | input | 12 | Pixels per line when line-end markers are absent |
| cfg_has_eol | input | 1 | 1: stream carries line-end markers |
| cfg_chk_en | input | 1 | 1: compare the line total at frame end |
| irq_ena | input | 3 | Per-event enable (bit0 too few, bit1 too many, bit2 discard) |
| irq_clr | input | 3 | Write-one-to-clear pulses for irq_raw |
| irq_raw | output | 3 | Sticky event bits |
| irq_stat | output | 3 | irq_raw masked by irq_ena |
| irq | output | 1 | OR of irq_stat |

## Verification
A wrong line or pixel count stays hidden until the end of the frame. It then shows up on the first clock edge after the frame-end beat, as a too-few or too-many bit set in the wrong direction or not set at all. A stuck frame-open state shows up at the next frame start as an unexpected discard bit, or at a stray frame end as an unexpected comparison. Faults in the raw, enable or clear path show up within one cycle of the event or clear pulse. For that reason the reference model is compared on every clock, and the flags are also checked against hand-computed values after each scenario.

// File: rtl/frm_chk_pkg.sv
`timescale 1ns/1ps
package frm_chk_pkg;
  localparam int unsigned IRQ_N = 3;
  localparam int unsigned EV_FEW  = 0;
  localparam int unsigned EV_MANY = 1;
  localparam int unsigned EV_DISC = 2;

  typedef struct packed {
    logic sof;
    logic pix;
    logic eol;
    logic eof;
  } beat_t;
endpackage

// File: rtl/frm_line_counter.sv
`timescale 1ns/1ps
module frm_line_counter
  import frm_chk_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_ok,
  input  beat_t            beat,
  input  logic [CNT_W-1:0] cfg_width,
  input  logic             cfg_has_eol,
  output logic             frame_open,
  output logic [CNT_W-1:0] line_total,
  output logic             close_fire,
  output logic             discard_fire
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W:0]   EXT_ONE = (CNT_W+1)'(1);

  logic             open_q;
  logic [CNT_W-1:0] lcnt_q, pcnt_q;
  logic [CNT_W-1:0] l_base, p_base, l_nx, p_nx;
  logic             open_now, lend;

  always_comb begin
    open_now = beat.sof | open_q;
    l_base   = beat.sof ? '0 : lcnt_q;
    p_base   = beat.sof ? '0 : pcnt_q;
    if (cfg_has_eol)
      lend = beat.eol;
    else
      lend = beat.pix && (cfg_width != '0) &&
             (({1'b0, p_base} + EXT_ONE) == {1'b0, cfg_width});
    l_nx = (lend && (l_base != CNT_MAX)) ? l_base + CNT_ONE : l_base;
    if (lend)
      p_nx = '0;
    else if (beat.pix && (p_base != CNT_MAX))
      p_nx = p_base + CNT_ONE;
    else
      p_nx = p_base;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      lcnt_q <= '0;
      pcnt_q <= '0;
    end else if (beat_ok && open_now) begin
      open_q <= ~beat.eof;
      lcnt_q <= l_nx;
      pcnt_q <= p_nx;
    end
  end

  assign frame_open   = open_q;
  assign line_total   = l_nx;
  assign close_fire   = beat_ok & open_now & beat.eof;
  assign discard_fire = beat_ok & beat.sof & open_q;

  // R7: a fresh frame start with no line or pixel in the beat restarts the count
  assert_sof_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ok && beat.sof && !beat.eol && !beat.pix && !beat.eof) |=> (lcnt_q == '0 && open_q));

  // R5: an accepted frame end closes the frame
  assert_eof_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ok && open_now && beat.eof) |=> !open_q);

  // R8: nothing opens a frame except a frame start
  assert_no_open_without_sof_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && !(beat_ok && beat.sof)) |=> !open_q);
endmodule

// File: rtl/frm_count_cmp.sv
`timescale 1ns/1ps
module frm_count_cmp #(
  parameter int CNT_W = 12
) (
  input  logic             fire,
  input  logic             chk_en,
  input  logic [CNT_W-1:0] seen,
  input  logic [CNT_W-1:0] want,
  output logic             too_few,
  output logic             too_many
);
  logic go;
  assign go       = fire & chk_en;
  assign too_few  = go & (seen < want);
  assign too_many = go & (seen > want);
endmodule

// File: rtl/frm_irq_bank.sv
`timescale 1ns/1ps
module frm_irq_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ena_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] stat_o,
  output logic         irq_o
);
  logic [N-1:0] raw_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) raw_q[i] <= 1'b0;
      else        raw_q[i] <= set_i[i] | (raw_q[i] & ~clr_i[i]);
    end

    // R9: an event in the same cycle as a clear leaves the bit set
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> raw_q[i]);

    // R9: a clear with no event empties the bit
    assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !raw_q[i]);

    // R10: the enable never changes a raw bit
    assert_raw_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i[i] && !clr_i[i]) |=> $stable(raw_q[i]));
  end

  assign raw_o  = raw_q;
  assign stat_o = raw_q & ena_i;
  assign irq_o  = |stat_o;
endmodule

// File: rtl/frm_line_checker.sv
`timescale 1ns/1ps
module frm_line_checker
  import frm_chk_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sof,
  input  logic             in_pix,
  input  logic             in_eol,
  input  logic             in_eof,
  input  logic [CNT_W-1:0] cfg_lines,
  input  logic [CNT_W-1:0] cfg_width,
  input  logic             cfg_has_eol,
  input  logic             cfg_chk_en,
  input  logic [IRQ_N-1:0] irq_ena,
  input  logic [IRQ_N-1:0] irq_clr,
  output logic [IRQ_N-1:0] irq_raw,
  output logic [IRQ_N-1:0] irq_stat,
  output logic             irq
);
  beat_t            beat;
  logic             beat_ok;
  logic             frame_open, close_fire, discard_fire;
  logic [CNT_W-1:0] line_total;
  logic             too_few, too_many;
  logic [IRQ_N-1:0] ev_set;

  assign in_ready = 1'b1;
  assign beat_ok  = in_valid & in_ready;
  assign beat     = '{sof: in_sof, pix: in_pix, eol: in_eol, eof: in_eof};

  frm_line_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .beat_ok      (beat_ok),
    .beat         (beat),
    .cfg_width    (cfg_width),
    .cfg_has_eol  (cfg_has_eol),
    .frame_open   (frame_open),
    .line_total   (line_total),
    .close_fire   (close_fire),
    .discard_fire (discard_fire)
  );

  frm_count_cmp #(.CNT_W(CNT_W)) u_cmp (
    .fire     (close_fire),
    .chk_en   (cfg_chk_en),
    .seen     (line_total),
    .want     (cfg_lines),
    .too_few  (too_few),
    .too_many (too_many)
  );

  always_comb begin
    ev_set          = '0;
    ev_set[EV_FEW]  = too_few;
    ev_set[EV_MANY] = too_many;
    ev_set[EV_DISC] = discard_fire;
  end

  frm_irq_bank #(.N(IRQ_N)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ev_set),
    .clr_i  (irq_clr),
    .ena_i  (irq_ena),
    .raw_o  (irq_raw),
    .stat_o (irq_stat),
    .irq_o  (irq)
  );

  // R6: with checking off, no count flag can rise
  assert_no_cmp_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_chk_en |=> (!$rose(irq_raw[EV_FEW]) && !$rose(irq_raw[EV_MANY])));

  // R7: a frame start inside an open frame is reported as a discard
  assert_discard_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && frame_open) |=> irq_raw[EV_DISC]);

  // R8: a stray frame end makes no comparison
  assert_stray_eof_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eof && !in_sof && !frame_open) |=>
      (!$rose(irq_raw[EV_FEW]) && !$rose(irq_raw[EV_MANY])));

  // R2: idle cycles cannot raise any flag
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (irq_raw & ~$past(irq_raw)) == '0);
endmodule

// File: tb/tb_frm_line_checker.sv
`timescale 1ns/1ps
module tb_frm_line_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 0, in_sof = 0, in_pix = 0, in_eol = 0, in_eof = 0;
  logic        in_ready;
  logic [11:0] cfg_lines = 12'd4, cfg_width = 12'd5;
  logic        cfg_has_eol = 1'b1, cfg_chk_en = 1'b1;
  logic [2:0]  irq_ena = 3'b000, irq_clr = 3'b000;
  logic [2:0]  irq_raw, irq_stat;
  logic        irq;

  int    n_run = 0, n_fail = 0;
  string phase = "R1";
  bit    done = 0;

  always #4 clk = ~clk;

  frm_line_checker dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_pix(in_pix), .in_eol(in_eol), .in_eof(in_eof),
    .cfg_lines(cfg_lines), .cfg_width(cfg_width), .cfg_has_eol(cfg_has_eol),
    .cfg_chk_en(cfg_chk_en), .irq_ena(irq_ena), .irq_clr(irq_clr),
    .irq_raw(irq_raw), .irq_stat(irq_stat), .irq(irq)
  );

  // behavioural reference
  int       m_open = 0, m_l = 0, m_p = 0;
  bit [2:0] m_raw = 0;
  always @(posedge clk) begin
    bit [2:0] s;
    int l, p;
    bit le;
    s = 0;
    if (!rst_n) begin
      m_open = 0; m_l = 0; m_p = 0; m_raw = 0;
    end else begin
      if (in_valid) begin
        if (in_sof && m_open != 0) s[2] = 1;
        if (in_sof || m_open != 0) begin
          l = in_sof ? 0 : m_l;
          p = in_sof ? 0 : m_p;
          if (cfg_has_eol) le = in_eol;
          else le = in_pix && cfg_width != 0 && (p + 1 == int'(cfg_width));
          if (le) begin
            if (l < 4095) l++;
            p = 0;
          end else if (in_pix && p < 4095) p++;
          if (in_eof && cfg_chk_en) begin
            if (l < int'(cfg_lines)) s[0] = 1;
            if (l > int'(cfg_lines)) s[1] = 1;
          end
          m_open = in_eof ? 0 : 1;
          m_l = l; m_p = p;
        end
      end
      m_raw = (m_raw & ~irq_clr) | s;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_run++;
      if (irq_raw !== m_raw || irq_stat !== (m_raw & irq_ena) ||
          irq !== |(m_raw & irq_ena) || in_ready !== 1'b1) begin
        n_fail++;
        $display("FAIL %s model: raw=%b stat=%b irq=%b rdy=%b expected raw=%b stat=%b",
                 phase, irq_raw, irq_stat, irq, in_ready, m_raw, m_raw & irq_ena);
      end
    end
  end

  task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic beat(bit s, bit p, bit e, bit f);
    in_valid = 1; in_sof = s; in_pix = p; in_eol = e; in_eof = f;
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_pix = 0; in_eol = 0; in_eof = 0; irq_clr = 0;
  endtask

  task automatic clear_all();
    irq_clr = 3'b111;
    @(negedge clk);
    irq_clr = 3'b000;
  endtask

  task automatic eol_frame(int n);
    beat(1, 0, 0, 0);
    for (int i = 0; i < n; i++) beat(0, 0, 1, 0);
    beat(0, 0, 0, 1);
  endtask

  task automatic pix_frame(int n);
    beat(1, 0, 0, 0);
    for (int i = 0; i < n; i++) beat(0, 1, 0, 0);
    beat(0, 0, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    phase = "R1";
    chk("R1 raw", irq_raw, 3'b000);
    chk("R1 stat/irq", {irq_stat[1:0], irq}, 3'b000);
    chk("R1 ready", {2'b00, in_ready}, 3'b001);

    phase = "R3"; cfg_has_eol = 1; cfg_chk_en = 1; cfg_lines = 4;
    eol_frame(4);                 chk("R3 exact", irq_raw, 3'b000);
    phase = "R5";
    eol_frame(3);                 chk("R5 too few", irq_raw, 3'b001);
    clear_all();                  chk("R9 cleared", irq_raw, 3'b000);
    eol_frame(6);                 chk("R5 too many", irq_raw, 3'b010);
    clear_all();
    phase = "R3";
    pix_frame(30);                chk("R3 pixels ignored", irq_raw, 3'b001);
    clear_all();

    phase = "R4"; cfg_has_eol = 0; cfg_width = 5; cfg_lines = 2;
    pix_frame(10);                chk("R4 width lines", irq_raw, 3'b000);
    pix_frame(9);                 chk("R4 partial line", irq_raw, 3'b001);
    clear_all();
    beat(1, 0, 0, 0);
    for (int i = 0; i < 5; i++) beat(0, 0, 1, 0);
    for (int i = 0; i < 10; i++) beat(0, 1, 0, 0);
    beat(0, 0, 0, 1);             chk("R4 eol ignored", irq_raw, 3'b000);
    cfg_width = 0; cfg_lines = 0;
    pix_frame(20);                chk("R4 width zero", irq_raw, 3'b000);
    cfg_lines = 1;
    pix_frame(20);                chk("R4 width zero few", irq_raw, 3'b001);
    clear_all();

    phase = "R6"; cfg_has_eol = 1; cfg_chk_en = 0; cfg_lines = 4;
    eol_frame(1);                 chk("R6 off few", irq_raw, 3'b000);
    eol_frame(9);                 chk("R6 off many", irq_raw, 3'b000);
    cfg_chk_en = 1;

    phase = "R7";
    beat(1, 0, 0, 0); beat(0, 0, 1, 0); beat(0, 0, 1, 0);
    beat(1, 0, 0, 0);             chk("R7 discard", irq_raw, 3'b100);
    for (int i = 0; i < 4; i++) beat(0, 0, 1, 0);
    beat(0, 0, 0, 1);             chk("R7 restart count", irq_raw, 3'b100);
    clear_all();

    phase = "R8";
    for (int i = 0; i < 6; i++) beat(0, 0, 1, 0);
    beat(0, 0, 0, 1);             chk("R8 stray eof", irq_raw, 3'b000);

    phase = "R2";
    beat(1, 0, 0, 0);
    for (int i = 0; i < 4; i++) beat(0, 0, 1, 0);
    in_valid = 0; in_eol = 1; in_sof = 1; in_eof = 1;
    repeat (3) @(negedge clk);
    in_eol = 0; in_sof = 0; in_eof = 0;
    beat(0, 0, 0, 1);             chk("R2 invalid ignored", irq_raw, 3'b000);

    phase = "R9";
    eol_frame(1);                 chk("R9 setup", irq_raw, 3'b001);
    beat(1, 0, 0, 0); beat(0, 0, 1, 0);
    irq_clr = 3'b001;
    beat(0, 0, 0, 1);             chk("R9 set wins", irq_raw, 3'b001);
    irq_clr = 3'b001; @(negedge clk); irq_clr = 0;
    chk("R9 clear", irq_raw, 3'b000);

    phase = "R10";
    beat(1, 0, 0, 0); beat(1, 0, 0, 0); beat(0, 0, 1, 0); beat(0, 0, 0, 1);
    chk("R10 raw", irq_raw, 3'b101);
    irq_ena = 3'b011; #1;
    chk("R10 stat", irq_stat, 3'b001);
    chk("R10 irq", {2'b00, irq}, 3'b001);
    irq_ena = 3'b010; #1;
    chk("R10 masked", {irq_stat[1:0], irq}, 3'b000);
    chk("R10 raw kept", irq_raw, 3'b101);
    clear_all();
    irq_ena = 3'b111;

    phase = "R11"; cfg_lines = 1;
    beat(1, 0, 1, 1);             chk("R11 one-beat frame", irq_raw, 3'b000);
    cfg_has_eol = 0; cfg_width = 1;
    beat(1, 1, 0, 1);             chk("R11 one-pixel frame", irq_raw, 3'b000);
    cfg_has_eol = 1; cfg_lines = 12'd4095;
    eol_frame(4100);              chk("R11 saturate", irq_raw, 3'b000);

    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule